// File: doc/BRIEF.md
# SMBus Isolation Arbitration Switch

This block lets software take over a private, bit-banged SMBus segment attached to an internal management controller, without any of that traffic reaching the shared external SMBus. Software works through one 8-bit register. Three of its bits are writable: an isolation request and the clock and data levels software wants to put on the wire. The readable bits return a grant flag and the clock and data levels present on the controller's own segment.

A routing multiplexer joins the controller's segment either to the external bus (grant low) or to the register's bit-bang lines (grant high). The grant follows the request only in a cycle where both segments that are switched are idle. A segment is idle when clock and data have both been high for a programmable number of cycles and no START has been seen since the last STOP. Lines are open-drain, and the block models them as drive-low enables; a bus level is the wired-AND of every driver. External bus levels pass through a two-flop synchronizer before they are used.

Software sets the request and polls until the grant reads 1, then toggles clock and data. To hand the bus back it returns both lines high, clears the request, and waits for the grant to read 0.

Top module: `smbus_iso_switch`

## Requirements
- R1: After reset the register reads 0x27 and neither external drive-low enable is asserted.
- R2: A write stores only bit 3 (request), bit 1 (data level) and bit 0 (clock level). Writes to bits 7:6, 5, 4 and 2 have no effect, and bits 7:6 always read 0.
- R3: A segment is idle once its clock and data have both been high for IDLE_CYC consecutive cycles and no START (data falling while clock is high) is open without a later STOP (data rising while clock is high). The grant copies the request only in a cycle where both the external and the internal segment are idle.
- R4: A request written while a START is open on the external bus leaves the grant at 0 until the STOP and at least IDLE_CYC further cycles have passed.
- R5: While the grant is 1, both external drive-low enables stay 0 whatever the bit-bang bits and the controller drive. The controller's segment then carries the wired-AND of the register bits 1:0 and the controller's own drivers.
- R6: While the grant is 0, the external clock enable is the inverse of bit 0 OR the controller's clock enable, and the external data enable is the inverse of bit 1 OR the controller's data enable. The controller's segment then follows the external bus through a two-flop synchronizer, so a level reaches the register within three cycles.
- R7: Bit 5 reads the clock level and bit 2 the data level on the controller's segment, and bit 4 reads the grant.
- R8: After the request is cleared, the grant stays 1 while a START is open on the internal segment. It falls only after the STOP and at least IDLE_CYC further idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write value |
| reg_rd_data | output | 8 | Register read value |
| ext_scl_in | input | 1 | External bus clock level (asynchronous) |
| ext_sda_in | input | 1 | External bus data level (asynchronous) |
| ext_scl_oe | output | 1 | Drive-low enable onto external clock |
| ext_sda_oe | output | 1 | Drive-low enable onto external data |
| mc_scl_oe | input | 1 | Controller drive-low enable on its clock |
| mc_sda_oe | input | 1 | Controller drive-low enable on its data |
| mc_scl_in | output | 1 | Clock level seen by the controller |
| mc_sda_in | output | 1 | Data level seen by the controller |

## Verification
Two things can fall in the same cycle: a request write and a START on the segment being switched. When that happens the grant must lose to the bus activity. The bench makes this happen by opening a START on the external bus from the bench's own master and then writing the request. It checks that the grant stays 0 through clock toggles and does not read 1 until at least IDLE_CYC cycles after the STOP. The release makes the same collision on the internal segment: a START bit-banged through the register just before the request is cleared must keep the grant high until the matching STOP.

// File: rtl/smbus_iso_pkg.sv
package smbus_iso_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } smb_pair_t;

    typedef struct packed {
        logic      req;
        smb_pair_t bang;
    } iso_ctl_t;

    localparam int REG_W   = 8;
    localparam int B_SCLW  = 0;
    localparam int B_SDAW  = 1;
    localparam int B_SDAR  = 2;
    localparam int B_REQ   = 3;
    localparam int B_GNT   = 4;
    localparam int B_SCLR  = 5;

    localparam iso_ctl_t CTL_RESET = '{req: 1'b0, bang: '{scl: 1'b1, sda: 1'b1}};

    function automatic smb_pair_t wired_and(smb_pair_t a, smb_pair_t b);
        return '{scl: a.scl & b.scl, sda: a.sda & b.sda};
    endfunction

    function automatic smb_pair_t level_from_oe(smb_pair_t oe);
        return '{scl: ~oe.scl, sda: ~oe.sda};
    endfunction

    function automatic logic [REG_W-1:0] pack_status(smb_pair_t seen, logic gnt, iso_ctl_t c);
        logic [REG_W-1:0] v;
        v         = '0;
        v[B_SCLW] = c.bang.scl;
        v[B_SDAW] = c.bang.sda;
        v[B_SDAR] = seen.sda;
        v[B_REQ]  = c.req;
        v[B_GNT]  = gnt;
        v[B_SCLR] = seen.scl;
        return v;
    endfunction

endpackage

// File: rtl/smbus_pair_sync.sv
module smbus_pair_sync
    import smbus_iso_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  smb_pair_t d,
    output smb_pair_t q
);
    smb_pair_t stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '{scl: 1'b1, sda: 1'b1};
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '{scl: 1'b1, sda: 1'b1};
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/smbus_idle_mon.sv
module smbus_idle_mon
    import smbus_iso_pkg::*;
#(
    parameter int IDLE_CYC = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  smb_pair_t line,
    output logic      idle
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(IDLE_CYC);

    smb_pair_t     prev;
    logic          busy;
    logic [CW-1:0] hi_cnt;
    logic          start_ev, stop_ev;

    assign start_ev = prev.scl & line.scl &  prev.sda & ~line.sda;
    assign stop_ev  = prev.scl & line.scl & ~prev.sda &  line.sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '{scl: 1'b1, sda: 1'b1};
            busy   <= 1'b0;
            hi_cnt <= '0;
        end else begin
            prev <= line;
            if (start_ev)     busy <= 1'b1;
            else if (stop_ev) busy <= 1'b0;
            if (!(line.scl && line.sda)) hi_cnt <= '0;
            else if (hi_cnt != CMAX)     hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign idle = ~busy && (hi_cnt == CMAX);

    // R4
    start_blocks_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !idle);

    // R3
    idle_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(idle) |-> ($past(line.scl) && $past(line.sda)));
endmodule

// File: rtl/smbus_iso_route.sv
module smbus_iso_route
    import smbus_iso_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      ext_idle,
    input  logic      iso_idle,
    input  smb_pair_t bang,
    input  smb_pair_t mc_oe,
    input  smb_pair_t ext_seen,
    output logic      grant,
    output smb_pair_t ext_oe,
    output smb_pair_t iso_line,
    output smb_pair_t mc_seen
);
    logic grant_q;

    always_ff @(posedge clk) begin
        if (rst)                       grant_q <= 1'b0;
        else if (ext_idle && iso_idle) grant_q <= req;
    end

    assign grant    = grant_q;
    assign iso_line = wired_and(bang, level_from_oe(mc_oe));
    assign mc_seen  = grant_q ? iso_line : ext_seen;

    always_comb begin
        if (grant_q) ext_oe = '{scl: 1'b0, sda: 1'b0};
        else         ext_oe = '{scl: ~bang.scl | mc_oe.scl, sda: ~bang.sda | mc_oe.sda};
    end

    // R3
    grant_move_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(grant_q) |-> $past(ext_idle && iso_idle));

    // R3
    grant_rise_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_q) |-> $past(req));

    // R8
    grant_fall_req_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(grant_q) |-> $past(!req && iso_idle));
endmodule

// File: rtl/smbus_iso_switch.sv
module smbus_iso_switch
    import smbus_iso_pkg::*;
#(
    parameter int IDLE_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             ext_scl_in,
    input  logic             ext_sda_in,
    output logic             ext_scl_oe,
    output logic             ext_sda_oe,
    input  logic             mc_scl_oe,
    input  logic             mc_sda_oe,
    output logic             mc_scl_in,
    output logic             mc_sda_in
);
    iso_ctl_t  ctl_q;
    smb_pair_t ext_raw, ext_seen, iso_line, mc_seen, ext_oe, mc_oe;
    logic      ext_idle, iso_idle, grant;

    assign ext_raw = '{scl: ext_scl_in, sda: ext_sda_in};
    assign mc_oe   = '{scl: mc_scl_oe,  sda: mc_sda_oe};

    // R2: only request and bit-bang bits are stored
    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else if (reg_wr_en) begin
            ctl_q.req      <= reg_wr_data[B_REQ];
            ctl_q.bang.scl <= reg_wr_data[B_SCLW];
            ctl_q.bang.sda <= reg_wr_data[B_SDAW];
        end
    end

    smbus_pair_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk), .rst (rst), .d (ext_raw), .q (ext_seen)
    );

    smbus_idle_mon #(.IDLE_CYC(IDLE_CYC)) i_ext_mon (
        .clk (clk), .rst (rst), .line (ext_seen), .idle (ext_idle)
    );

    smbus_idle_mon #(.IDLE_CYC(IDLE_CYC)) i_iso_mon (
        .clk (clk), .rst (rst), .line (iso_line), .idle (iso_idle)
    );

    smbus_iso_route i_route (
        .clk      (clk),
        .rst      (rst),
        .req      (ctl_q.req),
        .ext_idle (ext_idle),
        .iso_idle (iso_idle),
        .bang     (ctl_q.bang),
        .mc_oe    (mc_oe),
        .ext_seen (ext_seen),
        .grant    (grant),
        .ext_oe   (ext_oe),
        .iso_line (iso_line),
        .mc_seen  (mc_seen)
    );

    assign ext_scl_oe  = ext_oe.scl;
    assign ext_sda_oe  = ext_oe.sda;
    assign mc_scl_in   = mc_seen.scl;
    assign mc_sda_in   = mc_seen.sda;
    // R1: reset value follows from CTL_RESET and synchronizer reset
    assign reg_rd_data = pack_status(mc_seen, grant, ctl_q);

    // R5
    ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (!ext_scl_oe && !ext_sda_oe));

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> (reg_rd_data[1:0] == $past(reg_wr_data[1:0]))
                      && (reg_rd_data[B_REQ] == $past(reg_wr_data[B_REQ])));
endmodule

// File: tb/test_smbus_iso_switch.sv
module test_smbus_iso_switch;
    localparam int IDLE = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_scl_oe, ext_sda_oe, mc_scl_in, mc_sda_in;
    logic       om_scl = 1'b1, om_sda = 1'b1;
    logic       mc_scl_oe = 1'b0, mc_sda_oe = 1'b0;
    logic       ext_scl, ext_sda;
    logic       quiet_watch = 1'b0;
    logic       done = 1'b0;
    int         n_run = 0, n_fail = 0, ext_noise = 0;

    always #4 clk = ~clk;

    assign ext_scl = om_scl & ~ext_scl_oe;
    assign ext_sda = om_sda & ~ext_sda_oe;

    smbus_iso_switch #(.IDLE_CYC(IDLE)) i_smbus_iso_switch (
        .clk (clk), .rst (rst),
        .reg_wr_en (wr_en), .reg_wr_data (wr_data), .reg_rd_data (rd_data),
        .ext_scl_in (ext_scl), .ext_sda_in (ext_sda),
        .ext_scl_oe (ext_scl_oe), .ext_sda_oe (ext_sda_oe),
        .mc_scl_oe (mc_scl_oe), .mc_sda_oe (mc_sda_oe),
        .mc_scl_in (mc_scl_in), .mc_sda_in (mc_sda_in)
    );

    always @(negedge clk)
        if (quiet_watch && (ext_scl_oe || ext_sda_oe)) ext_noise++;

    function automatic logic [7:0] exp_rd(logic scl_lvl, logic gnt, logic req,
                                          logic sda_lvl, logic [1:0] bang);
        return {2'b00, scl_lvl, gnt, req, sda_lvl, bang};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [1:0] v;
        logic ms, md, es, ed, ok;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(rd_data == 8'h27, "R1 reset value", rd_data, 8'h27);
        chk({ext_scl_oe, ext_sda_oe} == 2'b00, "R1 no drive after reset",
            {ext_scl_oe, ext_sda_oe}, 0);

        // R2: read-only and reserved bits ignored
        wr(8'hF7);
        idle_cycles(3);
        chk(rd_data == 8'h27, "R2 write F7", rd_data, 8'h27);
        wr(8'hC4);
        chk({ext_scl_oe, ext_sda_oe} == 2'b11, "R6 lines driven low",
            {ext_scl_oe, ext_sda_oe}, 3);
        idle_cycles(3);
        chk(rd_data == 8'h00, "R2 write C4", rd_data, 8'h00);
        wr(8'h03);
        idle_cycles(3);

        // R6 / R7 random phase, grant low
        ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            v = 2'($urandom);
            ms = 1'($urandom); md = 1'($urandom);
            es = 1'($urandom); ed = 1'($urandom);
            @(negedge clk);
            mc_scl_oe = ms; mc_sda_oe = md; om_scl = es; om_sda = ed;
            wr({6'b0, v});
            chk({ext_scl_oe, ext_sda_oe} == {~v[0] | ms, ~v[1] | md}, "R6 drive enables",
                {ext_scl_oe, ext_sda_oe}, {~v[0] | ms, ~v[1] | md});
            idle_cycles(3);
            chk(rd_data == exp_rd(es & v[0] & ~ms, 1'b0, 1'b0, ed & v[1] & ~md, v),
                "R7 levels via external bus", rd_data,
                exp_rd(es & v[0] & ~ms, 1'b0, 1'b0, ed & v[1] & ~md, v));
        end

        @(negedge clk);
        mc_scl_oe = 0; mc_sda_oe = 0; om_scl = 1; om_sda = 1;
        wr(8'h03);
        idle_cycles(IDLE + 8);

        // R4: request during an open external START
        om_sda = 1'b0;
        idle_cycles(3);
        wr(8'h0B);
        idle_cycles(40);
        chk(rd_data[4] == 1'b0, "R4 grant held during START", rd_data[4], 0);
        om_scl = 1'b0; idle_cycles(5); om_scl = 1'b1; idle_cycles(5);
        om_scl = 1'b0; idle_cycles(5); om_scl = 1'b1; idle_cycles(5);
        chk(rd_data[4] == 1'b0, "R4 grant held during clocking", rd_data[4], 0);
        om_sda = 1'b1;
        cnt = 0;
        while (rd_data[4] == 1'b0 && cnt < 300) begin
            @(negedge clk); cnt++;
        end
        chk(rd_data[4] == 1'b1, "R3 grant after STOP", rd_data[4], 1);
        chk(cnt >= IDLE, "R4 idle window after STOP", cnt, IDLE);

        // R5 / R7 random phase, grant high
        quiet_watch = 1'b1;
        for (int i = 0; i < 40; i++) begin
            v = 2'($urandom);
            ms = 1'($urandom); md = 1'($urandom);
            @(negedge clk);
            mc_scl_oe = ms; mc_sda_oe = md;
            om_scl = 1'($urandom); om_sda = 1'($urandom);
            wr({4'b0, 1'b1, 1'b0, v});
            idle_cycles(2);
            chk(rd_data == exp_rd(v[0] & ~ms, 1'b1, 1'b1, v[1] & ~md, v),
                "R5 isolated segment levels", rd_data,
                exp_rd(v[0] & ~ms, 1'b1, 1'b1, v[1] & ~md, v));
            chk({mc_scl_in, mc_sda_in} == {v[0] & ~ms, v[1] & ~md}, "R5 controller sees bang",
                {mc_scl_in, mc_sda_in}, {v[0] & ~ms, v[1] & ~md});
        end
        quiet_watch = 1'b0;
        chk(ext_noise == 0, "R5 external enables quiet", ext_noise, 0);

        // R8: release blocked by open START on internal segment
        @(negedge clk);
        mc_scl_oe = 0; mc_sda_oe = 0; om_scl = 1; om_sda = 1;
        wr(8'h0B);
        idle_cycles(IDLE + 8);
        wr(8'h09);
        wr(8'h01);
        idle_cycles(40);
        chk(rd_data[4] == 1'b1, "R8 grant held with open START", rd_data[4], 1);
        wr(8'h03);
        cnt = 0;
        while (rd_data[4] == 1'b1 && cnt < 300) begin
            @(negedge clk); cnt++;
        end
        chk(rd_data[4] == 1'b0, "R8 grant released", rd_data[4], 0);
        chk(cnt >= IDLE - 1, "R8 idle window before release", cnt, IDLE - 1);

        // R6 after hand-back
        wr(8'h02);
        chk({ext_scl_oe, ext_sda_oe} == 2'b10, "R6 reconnected after release",
            {ext_scl_oe, ext_sda_oe}, 2);
        idle_cycles(3);
        chk(rd_data == 8'h06, "R7 reconnected read", rd_data, 8'h06);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule